// File: doc/BRIEF.md
# DMA Burst Sequencer with Fairness Gap

This block paces the bus-master bursts of a DMA engine. A one-cycle `start` pulse captures a byte count, a 3-bit burst-length code, a data-path width select, and two address-space select bits, one for the source and one for the destination. The byte count is turned into a number of beats. The transfer is then cut into chunks. Each chunk is one source-read burst followed by one destination-write burst with the same number of beats.

For each burst the sequencer raises a bus request and counts accepted beats until the burst is exhausted, then drops the request. After a completed burst the request stays low for a fixed fairness gap so that other masters can win the bus. A target retry ends the burst early. The sequencer then comes back after a single idle cycle with only the beats that are still owed. The last chunk of a transfer may be shorter than the decoded burst size. A space indicator tells the bus side whether the current phase addresses I/O or memory space.

The sequencer reports an unusable burst code at start and refuses to run. At the end of a transfer it raises a one-cycle completion pulse.

Top module: `dma_burst_seq`

## Requirements
- R1: With `wide`=1 (8-byte beats), burst code 0 and 1 give 4 beats per burst, 2 gives 8, 3 gives 16, 4 gives 32, and 5 and 6 give 64.
- R2: With `wide`=0 (4-byte beats), each code gives twice the R1 beat count (8, 8, 16, 32, 64, 128, 128). The transfer's beat total is the byte count divided by the beat size, rounded up.
- R3: A start with burst code 7 sets `cfgErr` in the next cycle, raises neither `busReq` nor `done`, and leaves `cfgErr` set until a later start with a valid code clears it.
- R4: After a burst ends by its last beat, with more work left, `busReq` stays low for exactly 4 cycles and then rises.
- R5: A cycle with `busReq`, `busGrant` and `busRetry` all high transfers no beat and ends the burst. `busReq` is then low for exactly one cycle, and the resumed burst carries only the beats still owed.
- R6: Every burst carries the smaller of the decoded burst size and the beats still left, so the final chunk may be partial.
- R7: Each chunk is a read burst (`phaseWrite`=0) followed by a write burst (`phaseWrite`=1) of the same beat count. A beat is accepted on a rising edge where `busReq`, `busGrant` and `busReady` are high and `busRetry` is low.
- R8: While `busReq` is high, `spaceIo` equals the captured source select during reads and the captured destination select during writes (1 = I/O space, 0 = memory space).
- R9: `done` is high for exactly one cycle, the cycle after the last write beat, with `busReq` low. A start with a byte count of 0 gives `done` two cycles after the start edge and no request.
- R10: Burst code, width and space selects are captured at start. Changes to them during a transfer have no effect.
- R11: After reset `busReq`, `done` and `cfgErr` are 0.
- R12: The first request of a transfer rises in the second cycle after the start edge, so it is low for one cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a transfer |
| byteCount | input | CNT_W | Bytes to move, captured at start |
| burstCode | input | 3 | Burst-length code, captured at start |
| wide | input | 1 | 1 = 8-byte beats, 0 = 4-byte beats |
| srcIo | input | 1 | Source space select, 1 = I/O |
| dstIo | input | 1 | Destination space select, 1 = I/O |
| busGrant | input | 1 | Bus granted to this master |
| busReady | input | 1 | Target accepts a beat this cycle |
| busRetry | input | 1 | Target ends the burst without a beat |
| busReq | output | 1 | Bus request |
| phaseWrite | output | 1 | 0 = source read, 1 = destination write |
| spaceIo | output | 1 | Address space of the current phase, 1 = I/O |
| done | output | 1 | Transfer-complete pulse |
| cfgErr | output | 1 | Reserved burst code seen at start |

## Verification
Most faults in the beat or remaining-count registers show up at the ports within one burst: a burst comes out too long or too short, or the read and write bursts of a chunk have different lengths. A fault in the gap counter or the retry path changes the number of low cycles between two requests, and that is visible at the very next rising edge of the request. A fault in the captured selects shows as a wrong `spaceIo` on the first beat of the affected phase. A fault in the completion logic either moves `done` away from the cycle after the last write beat or leaves the request running after it.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int BURST_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_REQ,
    ST_RETRY,
    ST_GAP
  } seqState_t;

  typedef struct packed {
    logic loadXfer;
    logic loadRead;
    logic loadWrite;
    logic beat;
    logic commit;
    logic gapLoad;
    logic gapTick;
  } seqCtrl_t;

endpackage

// File: rtl/dma_burst_size_dec.sv
module dma_burst_size_dec
  import dma_seq_pkg::*;
(
  input  logic [2:0]         code,
  input  logic               wide,
  output logic [BURST_W-1:0] beats,
  output logic               codeOk
);

  logic [2:0] expo;

  always_comb begin
    codeOk = 1'b1;
    unique case (code)
      3'd0, 3'd1: expo = 3'd2;
      3'd2:       expo = 3'd3;
      3'd3:       expo = 3'd4;
      3'd4:       expo = 3'd5;
      3'd5, 3'd6: expo = 3'd6;
      default: begin
        expo   = 3'd0;
        codeOk = 1'b0;
      end
    endcase
  end

  // narrow beats double the count, so the exponent grows by one
  assign beats = codeOk ? (BURST_W'(1) << (expo + {2'b00, ~wide})) : '0;

  // R2
  always_comb begin
    if (codeOk) begin
      pow_two_chk: assert ($countones(beats) == 1);
    end
  end

endmodule

// File: rtl/dma_seq_datapath.sv
module dma_seq_datapath
  import dma_seq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int GAP_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtrl_t         ctrl,
  input  logic [CNT_W-1:0] byteCount,
  input  logic [2:0]       burstCode,
  input  logic             wide,
  input  logic             srcIo,
  input  logic             dstIo,
  input  logic             phaseWrite,
  output logic             startCodeBad,
  output logic             remZero,
  output logic             lastChunk,
  output logic             burstLast,
  output logic             gapDone,
  output logic             spaceIo
);

  localparam int GW = $clog2(GAP_LEN + 1);

  logic [CNT_W-1:0]   remBeats, chunkQ, burstLeft, chunk, beatsIn;
  logic [CNT_W:0]     roundSum;
  logic [GW-1:0]      gapCnt;
  logic [2:0]         codeQ;
  logic               wideQ, srcQ, dstQ;
  logic [BURST_W-1:0] burstBeats;
  logic               codeOkQ;

  dma_burst_size_dec u_dec (
    .code  (codeQ),
    .wide  (wideQ),
    .beats (burstBeats),
    .codeOk(codeOkQ)
  );

  assign startCodeBad = &burstCode;
  assign roundSum     = {1'b0, byteCount} + (wide ? (CNT_W+1)'(7) : (CNT_W+1)'(3));
  assign beatsIn      = wide ? CNT_W'(roundSum >> 3) : CNT_W'(roundSum >> 2);
  assign chunk        = (remBeats < CNT_W'(burstBeats)) ? remBeats : CNT_W'(burstBeats);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remBeats  <= '0;
      chunkQ    <= '0;
      burstLeft <= '0;
      gapCnt    <= '0;
      codeQ     <= '0;
      wideQ     <= 1'b0;
      srcQ      <= 1'b0;
      dstQ      <= 1'b0;
    end else begin
      if (ctrl.loadXfer) begin
        remBeats <= beatsIn;
        codeQ    <= burstCode;
        wideQ    <= wide;
        srcQ     <= srcIo;
        dstQ     <= dstIo;
      end else if (ctrl.commit) begin
        remBeats <= remBeats - chunkQ;
      end
      if (ctrl.loadRead) begin
        chunkQ    <= chunk;
        burstLeft <= chunk;
      end else if (ctrl.loadWrite) begin
        burstLeft <= chunkQ;
      end else if (ctrl.beat) begin
        burstLeft <= burstLeft - 1'b1;
      end
      if (ctrl.gapLoad) begin
        gapCnt <= GW'(GAP_LEN - 1);
      end else if (ctrl.gapTick && gapCnt != '0) begin
        gapCnt <= gapCnt - 1'b1;
      end
    end
  end

  assign remZero   = (remBeats == '0);
  assign lastChunk = (remBeats == chunkQ);
  assign burstLast = (burstLeft == CNT_W'(1));
  assign gapDone   = (gapCnt == '0);
  assign spaceIo   = phaseWrite ? dstQ : srcQ;

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.beat |-> burstLeft != '0);

  // R1
  burst_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstLeft != '0) |-> (codeOkQ && burstLeft <= CNT_W'(burstBeats)));

  // R9
  commit_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.commit |-> remBeats >= chunkQ);

endmodule

// File: rtl/dma_seq_control.sv
module dma_seq_control
  import dma_seq_pkg::*;
#(
  parameter int GAP_LEN = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     startCodeBad,
  input  logic     remZero,
  input  logic     lastChunk,
  input  logic     burstLast,
  input  logic     gapDone,
  input  logic     busGrant,
  input  logic     busReady,
  input  logic     busRetry,
  output seqCtrl_t ctrl,
  output logic     busReq,
  output logic     phaseWrite,
  output logic     done,
  output logic     cfgErr
);

  seqState_t state, nextState;
  logic      nextPhase, nextDone, nextCfgErr;
  logic      beatFire, retryHit;

  assign busReq   = (state == ST_REQ);
  assign retryHit = busGrant && busRetry;
  assign beatFire = busGrant && busReady && !busRetry;

  always_comb begin
    ctrl       = '0;
    nextState  = state;
    nextPhase  = phaseWrite;
    nextDone   = 1'b0;
    nextCfgErr = cfgErr;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (startCodeBad) begin
            nextCfgErr = 1'b1;
          end else begin
            nextCfgErr    = 1'b0;
            ctrl.loadXfer = 1'b1;
            nextState     = ST_SETUP;
          end
        end
      end
      ST_SETUP: begin
        if (remZero) begin
          nextDone  = 1'b1;
          nextState = ST_IDLE;
        end else begin
          ctrl.loadRead = 1'b1;
          nextPhase     = 1'b0;
          nextState     = ST_REQ;
        end
      end
      ST_REQ: begin
        if (retryHit) begin
          nextState = ST_RETRY;
        end else if (beatFire) begin
          ctrl.beat = 1'b1;
          if (burstLast) begin
            if (phaseWrite && lastChunk) begin
              ctrl.commit = 1'b1;
              nextDone    = 1'b1;
              nextState   = ST_IDLE;
            end else begin
              ctrl.commit  = phaseWrite;
              ctrl.gapLoad = 1'b1;
              nextState    = ST_GAP;
            end
          end
        end
      end
      ST_RETRY: nextState = ST_REQ;
      ST_GAP: begin
        ctrl.gapTick = 1'b1;
        if (gapDone) begin
          nextState = ST_REQ;
          if (phaseWrite) begin
            ctrl.loadRead = 1'b1;
            nextPhase     = 1'b0;
          end else begin
            ctrl.loadWrite = 1'b1;
            nextPhase      = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phaseWrite <= 1'b0;
      done       <= 1'b0;
      cfgErr     <= 1'b0;
    end else begin
      state      <= nextState;
      phaseWrite <= nextPhase;
      done       <= nextDone;
      cfgErr     <= nextCfgErr;
    end
  end

  // run length of low request, for the gap checks below
  localparam int LW = $clog2(GAP_LEN + 2) + 1;
  logic [LW-1:0] lowRun;

  always_ff @(posedge clk) begin
    if (!rstN)            lowRun <= '0;
    else if (busReq)      lowRun <= '0;
    else if (lowRun != '1) lowRun <= lowRun + 1'b1;
  end

  // R4
  fair_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busReq) && $past(state) == ST_GAP) |-> lowRun == LW'(GAP_LEN));

  // R5
  retry_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busReq) && $past(state) == ST_RETRY) |-> lowRun == LW'(1));

  // R3
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (!busReq && !done));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busReq);

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
  import dma_seq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int GAP_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] byteCount,
  input  logic [2:0]       burstCode,
  input  logic             wide,
  input  logic             srcIo,
  input  logic             dstIo,
  input  logic             busGrant,
  input  logic             busReady,
  input  logic             busRetry,
  output logic             busReq,
  output logic             phaseWrite,
  output logic             spaceIo,
  output logic             done,
  output logic             cfgErr
);

  seqCtrl_t ctrl;
  logic     startCodeBad, remZero, lastChunk, burstLast, gapDone;

  dma_seq_control #(.GAP_LEN(GAP_LEN)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .startCodeBad(startCodeBad),
    .remZero     (remZero),
    .lastChunk   (lastChunk),
    .burstLast   (burstLast),
    .gapDone     (gapDone),
    .busGrant    (busGrant),
    .busReady    (busReady),
    .busRetry    (busRetry),
    .ctrl        (ctrl),
    .busReq      (busReq),
    .phaseWrite  (phaseWrite),
    .done        (done),
    .cfgErr      (cfgErr)
  );

  dma_seq_datapath #(.CNT_W(CNT_W), .GAP_LEN(GAP_LEN)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .byteCount   (byteCount),
    .burstCode   (burstCode),
    .wide        (wide),
    .srcIo       (srcIo),
    .dstIo       (dstIo),
    .phaseWrite  (phaseWrite),
    .startCodeBad(startCodeBad),
    .remZero     (remZero),
    .lastChunk   (lastChunk),
    .burstLast   (burstLast),
    .gapDone     (gapDone),
    .spaceIo     (spaceIo)
  );

endmodule

// File: tb/sim_dma_burst_seq.sv
module sim_dma_burst_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] byteCount = '0;
  logic [2:0]       burstCode = '0;
  logic             wide = 1'b0, srcIo = 1'b0, dstIo = 1'b0;
  logic             busGrant = 1'b1, busReady = 1'b1, busRetry = 1'b0;
  logic             busReq, phaseWrite, spaceIo, done, cfgErr;

  int total = 0;
  int bad   = 0;

  // observed segments
  int segLen[0:31], segPh[0:31], segSp[0:31], segGap[0:31];
  int nSeg, doneCyc, lowAtDone, cfgAt0, reqAtDone;
  bit doneSeen;
  // expected segments
  int expLen[0:31], expPh[0:31], expSp[0:31], expGap[0:31];
  int nExp;

  dma_burst_seq #(.CNT_W(CNT_W), .GAP_LEN(4)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount),
    .burstCode(burstCode), .wide(wide), .srcIo(srcIo), .dstIo(dstIo),
    .busGrant(busGrant), .busReady(busReady), .busRetry(busRetry),
    .busReq(busReq), .phaseWrite(phaseWrite), .spaceIo(spaceIo),
    .done(done), .cfgErr(cfgErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkEq(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sizeOf(int code, bit w);
    int s;
    case (code)
      0, 1:    s = 4;
      2:       s = 8;
      3:       s = 16;
      4:       s = 32;
      default: s = 64;
    endcase
    return w ? s : 2 * s;
  endfunction

  // drives one transfer and records every request segment
  task automatic runXfer(int bytes, int code, bit w, bit s, bit d, int retryAt);
    int  cur = 0, lowRun = 0, cyc = 0;
    bit  inBurst = 0, retryPending = (retryAt > 0);
    nSeg = 0; doneSeen = 0; doneCyc = -1; lowAtDone = -1; reqAtDone = -1;
    @(negedge clk);
    byteCount = CNT_W'(bytes); burstCode = 3'(code); wide = w; srcIo = s; dstIo = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R10: scramble the captured inputs after the start edge
    burstCode = 3'(code ^ 6); wide = ~w; srcIo = ~s; dstIo = ~d;
    byteCount = CNT_W'(bytes + 100);
    cfgAt0 = cfgErr;
    while (cyc < 3000) begin
      busRetry = 1'b0;
      if (done) begin
        doneSeen = 1; doneCyc = cyc; lowAtDone = lowRun; reqAtDone = busReq;
        if (inBurst) begin segLen[nSeg] = cur; nSeg++; inBurst = 0; end
        break;
      end
      if (busReq) begin
        if (!inBurst) begin
          inBurst = 1; cur = 0;
          segGap[nSeg] = lowRun; segPh[nSeg] = phaseWrite; segSp[nSeg] = spaceIo;
        end
        if (retryPending && nSeg == 0 && cur == retryAt) begin
          busRetry = 1'b1; retryPending = 0;
        end else begin
          cur++;
        end
        lowRun = 0;
      end else begin
        if (inBurst) begin segLen[nSeg] = cur; nSeg++; inBurst = 0; end
        lowRun++;
      end
      cyc++;
      @(negedge clk);
    end
    busRetry = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pushSeg(int len, int ph, int sp, int gap);
    expLen[nExp] = len; expPh[nExp] = ph; expSp[nExp] = sp; expGap[nExp] = gap;
    nExp++;
  endtask

  task automatic runAndCheck(string lenReq, int bytes, int code, bit w, bit s, bit d, int retryAt);
    int bb = w ? 8 : 4;
    int rem = (bytes + bb - 1) / bb;
    int sz = sizeOf(code, w);
    int gap = 1;
    bit first = 1;
    nExp = 0;
    while (rem > 0) begin
      int c = (rem < sz) ? rem : sz;
      if (first && retryAt > 0 && retryAt < c) begin
        pushSeg(retryAt, 0, s, gap);
        pushSeg(c - retryAt, 0, s, 1);
      end else begin
        pushSeg(c, 0, s, gap);
      end
      pushSeg(c, 1, d, 4);
      gap = 4; first = 0; rem -= c;
    end
    runXfer(bytes, code, w, s, d, retryAt);
    checkEq(lenReq, "segment count", nSeg, nExp);
    for (int i = 0; i < nExp && i < nSeg; i++) begin
      checkEq(lenReq, $sformatf("beats of segment %0d", i), segLen[i], expLen[i]);
      checkEq("R7", $sformatf("phase of segment %0d", i), segPh[i], expPh[i]);
      checkEq("R8", $sformatf("space of segment %0d", i), segSp[i], expSp[i]);
      if (i == 0)
        checkEq("R12", "low cycles before first request", segGap[i], expGap[i]);
      else if (expGap[i] == 1)
        checkEq("R5", $sformatf("low cycles after retry, seg %0d", i), segGap[i], 1);
      else
        checkEq("R4", $sformatf("fairness gap before seg %0d", i), segGap[i], 4);
    end
    checkEq("R9", "done seen", doneSeen, 1);
    checkEq("R9", "done right after last beat", lowAtDone, 0);
    checkEq("R9", "request low with done", reqAtDone, 0);
    checkEq("R9", "done one cycle wide", done, 0);
  endtask

  task automatic testReset();
    checkEq("R11", "busReq after reset", busReq, 0);
    checkEq("R11", "done after reset", done, 0);
    checkEq("R11", "cfgErr after reset", cfgErr, 0);
  endtask

  task automatic testWideCodes();
    runAndCheck("R1", 256, 3, 1'b1, 1'b1, 1'b0, 0);   // 32 beats, 16 per burst
    runAndCheck("R1", 16,  1, 1'b1, 1'b0, 1'b1, 0);   // 2 beats, partial
    runAndCheck("R1", 64,  2, 1'b1, 1'b1, 1'b1, 0);   // 8 beats exactly
    runAndCheck("R1", 320, 4, 1'b1, 1'b0, 1'b0, 0);   // 40 beats -> 32 + 8
    runAndCheck("R1", 600, 5, 1'b1, 1'b1, 1'b0, 0);   // 75 beats -> 64 + 11
    runAndCheck("R1", 40,  0, 1'b1, 1'b0, 1'b1, 0);   // 5 beats -> 4 + 1
  endtask

  task automatic testNarrowCodes();
    runAndCheck("R2", 40,  0, 1'b0, 1'b0, 1'b1, 0);   // 10 beats -> 8 + 2
    runAndCheck("R2", 512, 6, 1'b0, 1'b1, 1'b0, 0);   // 128 beats, one burst
    runAndCheck("R2", 130, 3, 1'b0, 1'b1, 1'b1, 0);   // rounds up to 33 beats
  endtask

  task automatic testPartial();
    runAndCheck("R6", 300, 5, 1'b1, 1'b0, 1'b1, 0);   // 38 beats < 64
  endtask

  task automatic testRetry();
    runAndCheck("R5", 96, 2, 1'b1, 1'b1, 1'b0, 3);    // 12 beats, retry after 3
    runAndCheck("R5", 64, 1, 1'b0, 1'b0, 1'b1, 7);    // retry on last beat of 8
  endtask

  task automatic testCapture();
    // R10: code 3 wide, inputs flipped to code 5 narrow right after start
    runAndCheck("R10", 192, 3, 1'b1, 1'b0, 1'b1, 0);
  endtask

  task automatic testZero();
    runXfer(0, 2, 1'b1, 1'b0, 1'b0, 0);
    checkEq("R9", "no request on zero count", nSeg, 0);
    checkEq("R9", "done cycle on zero count", doneCyc, 1);
  endtask

  task automatic testCfgErr();
    int reqSeen = 0, doneHit = 0;
    @(negedge clk);
    burstCode = 3'd7; byteCount = 16'd64; wide = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    checkEq("R3", "cfgErr after reserved code", cfgErr, 1);
    for (int i = 0; i < 12; i++) begin
      if (busReq) reqSeen++;
      if (done) doneHit++;
      @(negedge clk);
    end
    checkEq("R3", "requests while reserved", reqSeen, 0);
    checkEq("R3", "done while reserved", doneHit, 0);
    checkEq("R3", "cfgErr held", cfgErr, 1);
    runXfer(32, 1, 1'b1, 1'b0, 1'b0, 0);
    checkEq("R3", "cfgErr cleared by valid start", cfgAt0, 0);
    checkEq("R3", "valid transfer after error", doneSeen, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWideCodes();
    testNarrowCodes();
    testPartial();
    testRetry();
    testCapture();
    testZero();
    testCfgErr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule